// File: doc/BRIEF.md
# Paged Address Translation Unit

This unit turns a logical address into a physical address for a memory divided into pages of equal size, a power of two bytes each. The low bits of the logical address are the byte offset and pass through unchanged. The upper bits form the page number, and that number is replaced by a frame number. A small fully associative translation cache holds recent page-to-frame mappings. A hit returns the frame with no memory traffic. On a miss the unit reads one page table entry through a memory read port. The entry's address is the table base register plus the page number. A valid entry is loaded into the cache, replacing the least recently used mapping. An entry whose valid bit is clear raises a page fault.

A client waits for `xl_ready` and presents one request at a time. After it is accepted, the request ends with a one-cycle `xl_done` or a one-cycle `xl_fault`. Software-side logic changes the table base with `base_wr`. Writing the base empties the cache. If a translation is in flight, the new base and the emptying wait until that translation has finished.

Top module: `ptrans_unit`

## Requirements
- R1: `xl_paddr` equals the frame number placed above the unchanged low OFF_W offset bits (frame × page size + offset). With 256-byte pages and page 2 mapped to frame 14, logical 678 translates to 3750.
- R2: On a cache miss the unit makes exactly one memory read, at address `base + page number` modulo 2^BASE_W. It holds `mem_req` high and `mem_addr` stable until the cycle in which `mem_valid` is high.
- R3: On a cache hit, `xl_done` rises two clock edges after the accepting edge, and no memory read takes place.
- R4: A page table entry is FRM_W+1 bits wide. Bit FRM_W is the valid bit and bits FRM_W-1:0 hold the frame. When the valid bit is 0, `xl_fault` pulses instead of `xl_done`. Such an entry is never cached, so the same page walks again on its next access.
- R5: After a valid miss is resolved, the mapping is cached, and the next access to that page hits. The cache never holds two entries for the same page.
- R6: When all entries are full, a refill replaces the entry least recently touched. Both a hit and a refill count as a touch.
- R7: Empty entries are filled before any valid mapping is evicted. After the cache is emptied, NENT distinct valid pages all stay resident.
- R8: A base write while the unit is idle takes effect at the next edge and empties the cache. Later misses read from the new base.
- R9: A base write that arrives while a translation is in flight has no effect on that translation. This includes a write in the same cycle as the accepted request. The write is applied, and the cache emptied, when that translation finishes.
- R10: `xl_done` and `xl_fault` are one-cycle pulses and never occur together. `xl_ready` is low from acceptance until the pulse, and a request raised while the unit is busy is ignored.
- R11: After reset `xl_ready` is 1, `xl_done`, `xl_fault` and `mem_req` are 0, the base is 0 and the cache is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| xl_req | input | 1 | Translation request, taken when `xl_ready` is high |
| xl_laddr | input | LA_W | Logical address of the request |
| xl_ready | output | 1 | Unit idle and able to accept a request |
| xl_done | output | 1 | One-cycle pulse: `xl_paddr` holds a valid translation |
| xl_fault | output | 1 | One-cycle pulse: the page table entry was marked invalid |
| xl_paddr | output | FRM_W+OFF_W | Physical address |
| base_wr | input | 1 | Write strobe for the page table base |
| base_wdata | input | BASE_W | New page table base |
| mem_req | output | 1 | Page table read request, held until answered |
| mem_addr | output | BASE_W | Page table entry address |
| mem_valid | input | 1 | Read data valid |
| mem_rdata | input | FRM_W+1 | Page table entry: valid bit at the top, frame below |

## Verification
A base write and a translation can fall in the same cycle, either when the write comes with the request being accepted or when it lands while a walk waits on memory. The bench raises the write together with the request, in the lookup cycle, and at the first cycle of `mem_req`. In every case it judges the outcome against a reference model. The translation in flight must use the old base and the old cache contents. The next translation must find an empty cache and walk at the new base. Random traffic with random memory latency mixes these collisions with hits, misses, faults and evictions.

// File: rtl/ptrans_pkg.sv
// Package: shared types for the paged address translation unit.
// Assumes nothing beyond IEEE 1800-2017 enums.
package ptrans_pkg;

    // Control states of the translation sequencer
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,   // waiting for a request
        ST_LOOK = 2'd1,   // associative lookup of the captured page
        ST_WALK = 2'd2,   // page table read outstanding
        ST_RESP = 2'd3    // result pulse cycle
    } xl_state_e;

endpackage

// File: rtl/ptrans_cam.sv
// Module: fully associative page-to-frame store.
// Compares one page number against every entry. When several entries match,
// the lowest index is reported. Also reports the lowest empty entry.
// Assumes flush and write are never requested in the same cycle; flush wins.
module ptrans_cam #(
    parameter int N_ENT = 4,
    parameter int PN_W  = 4,
    parameter int FRM_W = 6,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic [PN_W-1:0]  look_pn,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [PN_W-1:0]  wr_pn,
    input  logic [FRM_W-1:0] wr_frm,
    output logic             hit,
    output logic [IDX_W-1:0] hit_idx,
    output logic [FRM_W-1:0] hit_frm,
    output logic             free_any,
    output logic [IDX_W-1:0] free_idx,
    output logic [N_ENT-1:0] match_vec
);

    logic [N_ENT-1:0] ent_vld;
    logic [PN_W-1:0]  ent_pn  [N_ENT];
    logic [FRM_W-1:0] ent_frm [N_ENT];

    for (genvar g = 0; g < N_ENT; g++) begin : g_ent
        // Per-entry storage: clear on flush, load on a targeted write
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                ent_vld[g] <= 1'b0;
                ent_pn[g]  <= '0;
                ent_frm[g] <= '0;
            end else if (flush) begin
                ent_vld[g] <= 1'b0;
            end else if (wr_en && (wr_idx == IDX_W'(g))) begin
                ent_vld[g] <= 1'b1;
                ent_pn[g]  <= wr_pn;
                ent_frm[g] <= wr_frm;
            end
        end

        // Per-entry compare
        assign match_vec[g] = ent_vld[g] && (ent_pn[g] == look_pn);
    end

    // Lowest-index matching entry
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end

    assign hit_frm = ent_frm[hit_idx];

    // Lowest-index empty entry
    always_comb begin
        free_any = 1'b0;
        free_idx = '0;
        for (int i = N_ENT - 1; i >= 0; i--) begin
            if (!ent_vld[i]) begin
                free_any = 1'b1;
                free_idx = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/ptrans_lru.sv
// Module: least-recently-used order tracker.
// Keeps an age per entry. The ages always form a permutation of 0..N_ENT-1,
// where 0 is the newest entry. A touch makes the entry newest and ages the
// entries that were younger than it. The victim is the entry with the
// highest age. Assumes touch_idx < N_ENT.
module ptrans_lru #(
    parameter int N_ENT = 4,
    parameter int IDX_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             touch_en,
    input  logic [IDX_W-1:0] touch_idx,
    output logic [IDX_W-1:0] victim_idx
);

    localparam logic [IDX_W-1:0] OLDEST = IDX_W'(N_ENT - 1);

    logic [IDX_W-1:0] age [N_ENT];

    // Age update on every touch
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < N_ENT; i++) age[i] <= IDX_W'(i);
        end else if (touch_en) begin
            for (int i = 0; i < N_ENT; i++) begin
                if (IDX_W'(i) == touch_idx)   age[i] <= '0;
                else if (age[i] < age[touch_idx]) age[i] <= age[i] + 1'b1;
            end
        end
    end

    // Entry holding the oldest age
    always_comb begin
        victim_idx = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (age[i] == OLDEST) victim_idx = IDX_W'(i);
        end
    end

endmodule

// File: rtl/ptrans_unit.sv
// Module: paged address translation unit (top).
// Splits the logical address, looks the page up in the mapping cache, walks
// a single-level page table on a miss, checks the valid bit, refills the
// cache and returns frame||offset. One translation is in flight at a time.
// Assumes the memory port answers each held mem_req with exactly one
// mem_valid cycle, after any latency.
module ptrans_unit
    import ptrans_pkg::*;
#(
    parameter int LA_W   = 12,
    parameter int OFF_W  = 8,
    parameter int FRM_W  = 6,
    parameter int BASE_W = 12,
    parameter int N_ENT  = 4
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   xl_req,
    input  logic [LA_W-1:0]        xl_laddr,
    output logic                   xl_ready,
    output logic                   xl_done,
    output logic                   xl_fault,
    output logic [FRM_W+OFF_W-1:0] xl_paddr,
    input  logic                   base_wr,
    input  logic [BASE_W-1:0]      base_wdata,
    output logic                   mem_req,
    output logic [BASE_W-1:0]      mem_addr,
    input  logic                   mem_valid,
    input  logic [FRM_W:0]         mem_rdata
);

    localparam int PN_W  = LA_W - OFF_W;
    localparam int PA_W  = FRM_W + OFF_W;
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1;

    xl_state_e         state;
    logic [PN_W-1:0]   req_pn;
    logic [OFF_W-1:0]  req_off;
    logic [BASE_W-1:0] base_q;
    logic              pend_vld;
    logic [BASE_W-1:0] pend_base;
    logic [PA_W-1:0]   res_paddr;
    logic              res_fault;

    logic              cam_hit;
    logic [IDX_W-1:0]  cam_hit_idx;
    logic [FRM_W-1:0]  cam_hit_frm;
    logic              cam_free_any;
    logic [IDX_W-1:0]  cam_free_idx;
    logic [N_ENT-1:0]  cam_match;
    logic [IDX_W-1:0]  lru_victim;

    logic              accept;
    logic              pte_ok;
    logic              refill_en;
    logic [IDX_W-1:0]  refill_idx;
    logic              touch_en;
    logic [IDX_W-1:0]  touch_idx;
    logic              apply_base;
    logic [BASE_W-1:0] apply_val;

    // Handshake and walk decode
    assign accept    = (state == ST_IDLE) && xl_req;
    assign pte_ok    = mem_rdata[FRM_W];
    assign refill_en = (state == ST_WALK) && mem_valid && pte_ok;

    // Refill slot: an existing copy of the page, else an empty slot, else the LRU victim
    always_comb begin
        if (cam_hit)           refill_idx = cam_hit_idx;
        else if (cam_free_any) refill_idx = cam_free_idx;
        else                   refill_idx = lru_victim;
    end

    // Recency update: lookup hits and refills
    assign touch_en  = refill_en || ((state == ST_LOOK) && cam_hit);
    assign touch_idx = refill_en ? refill_idx : cam_hit_idx;

    // Base update: at once when idle with no request, else deferred to the end of the translation
    always_comb begin
        apply_base = 1'b0;
        apply_val  = base_wdata;
        if (state == ST_IDLE && base_wr && !xl_req) begin
            apply_base = 1'b1;
        end else if (state == ST_RESP && (base_wr || pend_vld)) begin
            apply_base = 1'b1;
            apply_val  = base_wr ? base_wdata : pend_base;
        end
    end

    ptrans_cam #(
        .N_ENT (N_ENT),
        .PN_W  (PN_W),
        .FRM_W (FRM_W),
        .IDX_W (IDX_W)
    ) u_cam (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush     (apply_base),
        .look_pn   (req_pn),
        .wr_en     (refill_en),
        .wr_idx    (refill_idx),
        .wr_pn     (req_pn),
        .wr_frm    (mem_rdata[FRM_W-1:0]),
        .hit       (cam_hit),
        .hit_idx   (cam_hit_idx),
        .hit_frm   (cam_hit_frm),
        .free_any  (cam_free_any),
        .free_idx  (cam_free_idx),
        .match_vec (cam_match)
    );

    ptrans_lru #(
        .N_ENT (N_ENT),
        .IDX_W (IDX_W)
    ) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_idx  (touch_idx),
        .victim_idx (lru_victim)
    );

    // Sequencer: idle -> lookup -> (walk) -> result pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_IDLE: if (xl_req) state <= ST_LOOK;
                ST_LOOK: state <= cam_hit ? ST_RESP : ST_WALK;
                ST_WALK: if (mem_valid) state <= ST_RESP;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Request capture: page number and offset of the accepted address
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_pn  <= '0;
            req_off <= '0;
        end else if (accept) begin
            req_pn  <= xl_laddr[LA_W-1:OFF_W];
            req_off <= xl_laddr[OFF_W-1:0];
        end
    end

    // Result register: frame above the offset, or the fault flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_paddr <= '0;
            res_fault <= 1'b0;
        end else if (state == ST_LOOK && cam_hit) begin
            res_paddr <= {cam_hit_frm, req_off};
            res_fault <= 1'b0;
        end else if (state == ST_WALK && mem_valid) begin
            res_paddr <= {mem_rdata[FRM_W-1:0], req_off};
            res_fault <= !pte_ok;
        end
    end

    // Base register and the deferred write held while busy
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            base_q    <= '0;
            pend_vld  <= 1'b0;
            pend_base <= '0;
        end else if (apply_base) begin
            base_q   <= apply_val;
            pend_vld <= 1'b0;
        end else if (base_wr) begin
            pend_vld  <= 1'b1;
            pend_base <= base_wdata;
        end
    end

    assign xl_ready = (state == ST_IDLE);
    assign xl_done  = (state == ST_RESP) && !res_fault;
    assign xl_fault = (state == ST_RESP) && res_fault;
    assign xl_paddr = res_paddr;
    assign mem_req  = (state == ST_WALK);
    assign mem_addr = base_q + BASE_W'(req_pn);

endmodule

// File: rtl/ptrans_chk.sv
// Module: assertion checker for ptrans_unit, bound to every instance.
// Observes ports plus the cache compare vector; keeps one register of its own.
module ptrans_chk #(
    parameter int LA_W   = 12,
    parameter int OFF_W  = 8,
    parameter int FRM_W  = 6,
    parameter int BASE_W = 12,
    parameter int N_ENT  = 4
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   xl_req,
    input logic [LA_W-1:0]        xl_laddr,
    input logic                   xl_ready,
    input logic                   xl_done,
    input logic                   xl_fault,
    input logic [FRM_W+OFF_W-1:0] xl_paddr,
    input logic                   mem_req,
    input logic [BASE_W-1:0]      mem_addr,
    input logic                   mem_valid,
    input logic [N_ENT-1:0]       cam_match
);

    logic [OFF_W-1:0] chk_off;

    // Offset of the last accepted request
    always_ff @(posedge clk) begin
        if (!rst_n)                 chk_off <= '0;
        else if (xl_ready && xl_req) chk_off <= xl_laddr[OFF_W-1:0];
    end

    p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        xl_done |-> (xl_paddr[OFF_W-1:0] == chk_off));

    p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_valid) |=> (mem_req && $stable(mem_addr)));

    p_fault_walk_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xl_fault |-> $past(mem_valid));

    p_unique_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(cam_match) <= 1);

    p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_done || xl_fault) |=> (!xl_done && !xl_fault && xl_ready));

    p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(xl_done && xl_fault));

    p_busy_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_ready && xl_req) |=> !xl_ready);

endmodule

bind ptrans_unit ptrans_chk #(
    .LA_W   (LA_W),
    .OFF_W  (OFF_W),
    .FRM_W  (FRM_W),
    .BASE_W (BASE_W),
    .N_ENT  (N_ENT)
) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .xl_req    (xl_req),
    .xl_laddr  (xl_laddr),
    .xl_ready  (xl_ready),
    .xl_done   (xl_done),
    .xl_fault  (xl_fault),
    .xl_paddr  (xl_paddr),
    .mem_req   (mem_req),
    .mem_addr  (mem_addr),
    .mem_valid (mem_valid),
    .cam_match (cam_match)
);

// File: tb/ptrans_unit_tb.sv
// Bench for ptrans_unit: directed corner cases, then seeded random traffic.
// Outcomes are judged against a behavioural LRU model and a page table array.
module ptrans_unit_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LA_W   = 12;
    localparam int OFF_W  = 8;
    localparam int FRM_W  = 6;
    localparam int BASE_W = 12;
    localparam int N_ENT  = 4;
    localparam int PA_W   = FRM_W + OFF_W;
    localparam int TBL    = 1 << BASE_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              xl_req = 1'b0;
    logic [LA_W-1:0]   xl_laddr = '0;
    logic              xl_ready;
    logic              xl_done;
    logic              xl_fault;
    logic [PA_W-1:0]   xl_paddr;
    logic              base_wr = 1'b0;
    logic [BASE_W-1:0] base_wdata = '0;
    logic              mem_req;
    logic [BASE_W-1:0] mem_addr;
    logic              mem_valid = 1'b0;
    logic [FRM_W:0]    mem_rdata = '0;

    int errors = 0;
    int checks = 0;
    int nreads = 0;
    logic [BASE_W-1:0] last_raddr = '0;
    logic [FRM_W:0]    pt [TBL];

    // reference state: base and pages in recency order (index 0 newest)
    logic [BASE_W-1:0] m_base = '0;
    int                m_cnt = 0;
    int                m_pg [N_ENT];

    ptrans_unit #(
        .LA_W(LA_W), .OFF_W(OFF_W), .FRM_W(FRM_W), .BASE_W(BASE_W), .N_ENT(N_ENT)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .xl_req(xl_req), .xl_laddr(xl_laddr),
        .xl_ready(xl_ready), .xl_done(xl_done), .xl_fault(xl_fault),
        .xl_paddr(xl_paddr), .base_wr(base_wr), .base_wdata(base_wdata),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_valid(mem_valid),
        .mem_rdata(mem_rdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Memory model: answers each held request after a random latency
    initial begin
        forever begin
            @(negedge clk);
            if (mem_req && !mem_valid) begin
                repeat ($urandom % 4) @(negedge clk);
                mem_rdata  = pt[mem_addr];
                last_raddr = mem_addr;
                nreads++;
                mem_valid  = 1'b1;
                @(negedge clk);
                mem_valid  = 1'b0;
            end
        end
    end

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    function automatic int m_find(input int pg);
        for (int i = 0; i < m_cnt; i++) if (m_pg[i] == pg) return i;
        return -1;
    endfunction

    task automatic m_touch(input int pg);
        int pos = m_find(pg);
        if (pos < 0) begin
            pos = (m_cnt < N_ENT) ? m_cnt : N_ENT - 1;
            if (m_cnt < N_ENT) m_cnt++;
        end
        for (int i = pos; i > 0; i--) m_pg[i] = m_pg[i-1];
        m_pg[0] = pg;
    endtask

    task automatic wr_base(input logic [BASE_W-1:0] nb);
        @(negedge clk);
        while (!xl_ready) @(negedge clk);
        base_wr = 1'b1; base_wdata = nb;
        @(negedge clk);
        base_wr = 1'b0;
        m_base = nb; m_cnt = 0;
    endtask

    // One translation. wmode: 0 none, 1 base write with the request,
    // 2 base write in the lookup cycle, 3 base write at walk start.
    // junk: keep a request raised with other addresses while busy.
    task automatic xlat(input logic [LA_W-1:0] la, input int wmode,
                        input logic [BASE_W-1:0] nb, input bit junk, input string tag);
        int pn = int'(la[LA_W-1:OFF_W]);
        logic [BASE_W-1:0] ea = m_base + BASE_W'(pn);
        logic [FRM_W:0] pte = pt[ea];
        bit ehit = (m_find(pn) >= 0);
        int r0, k;
        bit wrote = 0;
        @(negedge clk);
        while (!xl_ready) @(negedge clk);
        r0 = nreads;
        xl_req = 1'b1; xl_laddr = la;
        if (wmode == 1) begin base_wr = 1'b1; base_wdata = nb; wrote = 1; end
        k = 0;
        forever begin
            @(negedge clk);
            k++;
            base_wr = 1'b0;
            xl_req  = junk;
            if (junk) xl_laddr = LA_W'($urandom);
            if (xl_done || xl_fault) begin
                xl_req = 1'b0;
                break;
            end
            chk(!xl_ready, {tag, " R10 ready low while busy"}, xl_ready, 0);
            if ((wmode == 2 && k == 1) || (wmode == 3 && mem_req && !wrote)) begin
                base_wr = 1'b1; base_wdata = nb; wrote = 1;
            end
        end
        chk(xl_fault == !pte[FRM_W], {tag, " R4 fault flag"}, xl_fault, !pte[FRM_W]);
        if (pte[FRM_W])
            chk(xl_paddr == {pte[FRM_W-1:0], la[OFF_W-1:0]}, {tag, " R1 physical address"},
                xl_paddr, {pte[FRM_W-1:0], la[OFF_W-1:0]});
        chk((nreads - r0) == (ehit ? 0 : 1), {tag, " R2/R3 read count, R5/R6/R7 hit"},
            nreads - r0, ehit ? 0 : 1);
        if (!ehit) chk(last_raddr == ea, {tag, " R2 walk address"}, last_raddr, ea);
        else       chk(k == 2, {tag, " R3 hit latency"}, k, 2);
        @(negedge clk);
        chk(!xl_done && !xl_fault && xl_ready, {tag, " R10 single pulse"},
            {xl_done, xl_fault, xl_ready}, 1);
        if (ehit || pte[FRM_W]) m_touch(pn);
        if (wrote) begin m_base = nb; m_cnt = 0; end
    endtask

    initial begin
        void'($urandom(32'd1234));
        for (int i = 0; i < TBL; i++)
            pt[i] = {(i % 7) != 3, FRM_W'((i * 13 + 5) % 64)};
        pt[2] = {1'b1, 6'd14};
        pt[9] = {1'b0, 6'd33};
        for (int i = 1; i <= 6; i++) if (i != 2) pt[i][FRM_W] = 1'b1;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(xl_ready && !xl_done && !xl_fault && !mem_req, "R11 reset state",
            {xl_ready, xl_done, xl_fault, mem_req}, 4'b1000);

        xlat(12'd678, 0, 0, 0, "R1 ref 678");
        chk(xl_paddr == 14'd3750, "R1 678 -> 3750", xl_paddr, 3750);
        xlat(12'd683, 0, 0, 0, "R5 refill hit");
        xlat(12'd2320, 0, 0, 0, "R4 invalid entry");
        xlat(12'd2400, 0, 0, 1, "R4 invalid not cached");

        wr_base(0);
        xlat(12'h1_10, 0, 0, 0, "R7 fill a");
        xlat(12'h3_20, 0, 0, 0, "R7 fill b");
        xlat(12'h4_30, 0, 0, 0, "R7 fill c");
        xlat(12'h5_40, 0, 0, 0, "R7 fill d");
        xlat(12'h3_21, 0, 0, 0, "R7 resident b");
        xlat(12'h4_22, 0, 0, 0, "R7 resident c");
        xlat(12'h5_23, 0, 0, 0, "R7 resident d");
        xlat(12'h1_24, 0, 0, 1, "R7 resident a");
        xlat(12'h6_00, 0, 0, 0, "R6 evict oldest");
        xlat(12'h3_01, 0, 0, 0, "R6 evicted page misses");
        xlat(12'h1_02, 0, 0, 0, "R6 recent page hits");

        wr_base(12'd16);
        xlat(12'h2_05, 0, 0, 0, "R8 new base walk");
        xlat(12'h7_06, 3, 12'd100, 0, "R9 write during walk");
        xlat(12'h7_07, 0, 0, 0, "R9 deferred base applied");
        xlat(12'h7_08, 1, 12'd4094, 0, "R9 write with request");
        xlat(12'h3_09, 2, 12'd40, 0, "R9 write in lookup");
        xlat(12'h3_0a, 0, 0, 0, "R9 after lookup write");
        wr_base(12'd4090);
        xlat(12'hF_0b, 0, 0, 0, "R2 base wrap");

        for (int n = 0; n < 400; n++) begin
            int sel = $urandom % 20;
            logic [LA_W-1:0] la = {4'($urandom % 8), 8'($urandom)};
            logic [BASE_W-1:0] nb = BASE_W'($urandom % 64);
            if (sel == 0)      wr_base(nb);
            else if (sel == 1) xlat(la, 1, nb, 0, "rnd R9");
            else if (sel == 2) xlat(la, 2, nb, 1, "rnd R9");
            else if (sel == 3) xlat(la, 3, nb, 0, "rnd R9");
            else               xlat(la, 0, 0, sel[0], "rnd R6");
        end

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule